// File: doc/BRIEF.md
# Receive gate delay generator

This block opens the receive window of an ultrasound front end. Each transmit burst begins with a one-cycle start strobe. The block then produces a GATE pulse with the same width as the transmit envelope, shifted later by a programmable number of clock ticks. The delay stands for the wanted sample depth. The round-trip time through water (2 × depth / 1540 m/s) multiplied by the clock rate gives the tick count. For example, 1.5 cm at a 20 MHz clock is about 390 ticks. That conversion is done outside the block, and the block takes the finished tick count.

The delay and the envelope width are captured on the strobe, so software may reprogram them at any time without disturbing the window in progress. A strobe that arrives while a window is still pending or open abandons it and starts timing again from the new strobe.

Timing convention: the strobe is sampled at clock edge k. The transmit envelope produced from the same strobe is high from the cycle after edge k. GATE is high in the cycles after edges k+D through k+D+L−1, where D is the delay and L is the length.

Top module: `rx_gate_delay`

## Requirements
- R1: After reset, and in the cycle after any cycle with `rst` high, `gate` is low.
- R2: With delay D ≥ 1 and length L ≥ 1 sampled on a strobe at edge k, `gate` is low after edges k through k+D−1 and first goes high in the cycle after edge k+D.
- R3: With delay 0 and L ≥ 1, `gate` is high in the cycle right after the strobe edge, which is the same cycle in which the transmit envelope rises.
- R4: Once open, `gate` stays high for exactly L consecutive cycles and then returns low, unless a new strobe arrives.
- R5: A strobe with length 0 produces no gate window; `gate` stays low.
- R6: `gate_dly` and `pulse_len` are used only in the strobe cycle. Changing them during a window has no effect on that window.
- R7: A strobe that arrives while a window is pending or open aborts that window. Timing restarts from the new strobe, using the new delay and length.
- R8: A delay up to the full `gate_dly` range (for example, 390 ticks) is honoured exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_start | input | 1 | One-cycle transmit burst start strobe |
| pulse_len | input | LEN_W | Transmit envelope width in ticks, sampled on the strobe |
| gate_dly | input | DLY_W | Depth delay in ticks, sampled on the strobe |
| gate | output | 1 | Receive window |

## Verification
The hardest situation to reach is a strobe that lands inside a live window. Three cases matter: the new strobe arrives while the delay is still counting, while the gate is open, or while the gate is open and the new delay is zero, so the gate must stay high without a gap. The bench first starts a long window and waits a chosen number of cycles. It then issues the second strobe and compares the whole trace against one computed from the second strobe alone. Every burst also scrambles both configuration inputs right after the strobe, so any late sampling shows up as a shifted or resized window.

// File: rtl/rx_gate_pkg.sv
package rx_gate_pkg;

    localparam int DLY_W_DEF = 10;
    localparam int LEN_W_DEF = 6;

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_WAIT = 2'd1,
        GS_OPEN = 2'd2
    } gate_state_e;

    // State entered when a strobe is accepted.
    function automatic gate_state_e entry_state(input logic dly_zero, input logic len_zero);
        if (len_zero)
            return GS_IDLE;
        else if (dly_zero)
            return GS_OPEN;
        else
            return GS_WAIT;
    endfunction

endpackage

// File: rtl/gate_len_hold.sv
module gate_len_hold #(
    parameter int LEN_W = rx_gate_pkg::LEN_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    output logic [LEN_W-1:0] len_q
);
    always_ff @(posedge clk) begin
        if (rst)
            len_q <= '0;
        else if (load)
            len_q <= len_in;
    end
endmodule

// File: rtl/gate_timer.sv
module gate_timer
    import rx_gate_pkg::*;
#(
    parameter int DLY_W = DLY_W_DEF,
    parameter int LEN_W = LEN_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DLY_W-1:0] dly_now,
    input  logic [LEN_W-1:0] len_now,
    input  logic [LEN_W-1:0] len_held,
    output logic             open
);
    localparam int CNT_W = (DLY_W > LEN_W) ? DLY_W : LEN_W;

    gate_state_e      state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] start_cnt;

    // Counter preload on a strobe: the remaining ticks of the first phase minus one.
    always_comb begin
        if (len_now == '0)
            start_cnt = '0;
        else if (dly_now == '0)
            start_cnt = CNT_W'(len_now) - CNT_W'(1);
        else
            start_cnt = CNT_W'(dly_now) - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= GS_IDLE;
            cnt   <= '0;
        end else if (start) begin
            state <= entry_state(dly_now == '0, len_now == '0);
            cnt   <= start_cnt;
        end else begin
            unique case (state)
                GS_WAIT: begin
                    if (cnt == '0) begin
                        state <= GS_OPEN;
                        cnt   <= CNT_W'(len_held) - CNT_W'(1);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                GS_OPEN: begin
                    if (cnt == '0)
                        state <= GS_IDLE;
                    else
                        cnt <= cnt - CNT_W'(1);
                end
                default: begin
                    state <= GS_IDLE;
                end
            endcase
        end
    end

    assign open = (state == GS_OPEN);
endmodule

// File: rtl/rx_gate_delay.sv
module rx_gate_delay
    import rx_gate_pkg::*;
#(
    parameter int DLY_W = DLY_W_DEF,
    parameter int LEN_W = LEN_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             burst_start,
    input  logic [LEN_W-1:0] pulse_len,
    input  logic [DLY_W-1:0] gate_dly,
    output logic             gate
);
    logic [LEN_W-1:0] len_held;

    gate_len_hold #(.LEN_W(LEN_W)) u_len (
        .clk    (clk),
        .rst    (rst),
        .load   (burst_start),
        .len_in (pulse_len),
        .len_q  (len_held)
    );

    gate_timer #(.DLY_W(DLY_W), .LEN_W(LEN_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (burst_start),
        .dly_now  (gate_dly),
        .len_now  (pulse_len),
        .len_held (len_held),
        .open     (gate)
    );
endmodule

// File: rtl/rx_gate_delay_chk.sv
module rx_gate_delay_chk #(
    parameter int DLY_W = 10,
    parameter int LEN_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             burst_start,
    input logic [LEN_W-1:0] pulse_len,
    input logic [DLY_W-1:0] gate_dly,
    input logic             gate
);
    logic             rst_q;
    logic [LEN_W-1:0] ref_len;
    logic [DLY_W-1:0] ref_dly;
    logic [DLY_W:0]   since;
    logic [LEN_W:0]   hi_cnt;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            ref_len <= '0;
            ref_dly <= '0;
            since   <= '0;
            hi_cnt  <= '0;
        end else if (burst_start) begin
            ref_len <= pulse_len;
            ref_dly <= gate_dly;
            since   <= '0;
            hi_cnt  <= '0;
        end else begin
            if (since != '1)
                since <= since + 1'b1;
            if (gate && hi_cnt != '1)
                hi_cnt <= hi_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_q)
            assert_reset_low_R1: assert (!gate);
    end

    // R2, R6, R8: rise lands exactly at the latched delay.
    assert_rise_at_delay_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(gate) && !$past(burst_start)) |-> (since == {1'b0, ref_dly}));

    assert_zero_delay_R3: assert property (@(posedge clk) disable iff (rst)
        (burst_start && gate_dly == '0 && pulse_len != '0) |=> gate);

    assert_width_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (gate && !$past(burst_start)) |-> (hi_cnt < {1'b0, ref_len}));

    assert_width_full_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(gate) && !$past(burst_start)) |-> (hi_cnt == {1'b0, ref_len}));

    assert_no_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (burst_start && pulse_len == '0) |=> !gate);

    assert_restart_closes_R7: assert property (@(posedge clk) disable iff (rst)
        (burst_start && gate_dly != '0) |=> !gate);
endmodule

bind rx_gate_delay rx_gate_delay_chk #(.DLY_W(DLY_W), .LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .burst_start (burst_start),
    .pulse_len   (pulse_len),
    .gate_dly    (gate_dly),
    .gate        (gate)
);

// File: tb/rx_gate_delay_bench.sv
module rx_gate_delay_bench;
    localparam int DLY_W = 10;
    localparam int LEN_W = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             burst_start = 1'b0;
    logic [LEN_W-1:0] pulse_len = '0;
    logic [DLY_W-1:0] gate_dly = '0;
    logic             gate;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rx_gate_delay #(.DLY_W(DLY_W), .LEN_W(LEN_W)) u_rx_gate_delay (
        .clk(clk), .rst(rst), .burst_start(burst_start),
        .pulse_len(pulse_len), .gate_dly(gate_dly), .gate(gate)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobe on the next edge; returns at the negedge just after it.
    task automatic strobe(input int d, input int l);
        @(negedge clk);
        burst_start = 1'b1;
        gate_dly    = DLY_W'(d);
        pulse_len   = LEN_W'(l);
        @(negedge clk);
        burst_start = 1'b0;
        gate_dly    = '1;   // scrambled after the strobe (R6)
        pulse_len   = '1;
    endtask

    // Compare the gate trace after a strobe with the window computed from d and l.
    task automatic trace(input int d, input int l, input string req);
        int bad = 0;
        int first = -1;
        for (int n = 1; n <= d + l + 3; n++) begin
            bit exp = (l > 0) && (n >= d + 1) && (n <= d + l);
            if (gate !== exp) begin
                bad++;
                if (first < 0) first = n;
            end
            @(negedge clk);
        end
        if (bad != 0)
            $display("FAIL detail %s d=%0d l=%0d first bad cycle %0d", req, d, l, first);
        check(bad == 0, req, bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(gate == 1'b0, "R1 reset state", int'(gate), 0);

        // Exhaustive sweep over a small delay/length grid.
        for (int d = 0; d <= 6; d++) begin
            for (int l = 0; l <= 5; l++) begin
                strobe(d, l);
                if (l == 0)      trace(d, l, "R5 zero length");
                else if (d == 0) trace(d, l, "R3 zero delay");
                else             trace(d, l, "R2 R4 R6 delayed window");
            end
        end

        // R8: deep setting, about 1.5 cm at 20 MHz.
        strobe(390, 10);
        trace(390, 10, "R8 long delay");
        strobe(1023, 63);
        trace(1023, 63, "R8 full range");

        // R7: restart during the delay phase.
        strobe(8, 5);
        repeat (3) @(negedge clk);
        strobe(4, 3);
        trace(4, 3, "R7 restart while waiting");

        // R7: restart while open, with a new nonzero delay.
        strobe(8, 5);
        repeat (9) @(negedge clk);
        check(gate == 1'b1, "R7 window open before restart", int'(gate), 1);
        strobe(4, 2);
        trace(4, 2, "R7 restart while open");

        // R7: restart while open, zero delay keeps gate high.
        strobe(2, 6);
        repeat (3) @(negedge clk);
        strobe(0, 4);
        trace(0, 4, "R7 zero delay restart");

        // R7: restart with zero length closes the window.
        strobe(1, 6);
        repeat (2) @(negedge clk);
        strobe(3, 0);
        trace(3, 0, "R7 R5 restart zero length");

        // R6: explicit mid-window reprogramming.
        strobe(3, 4);
        gate_dly  = DLY_W'(1);
        pulse_len = LEN_W'(20);
        trace(3, 4, "R6 inputs changed mid window");

        // R1: reset while gate is open.
        strobe(1, 8);
        repeat (3) @(negedge clk);
        check(gate == 1'b1, "R1 gate open before reset", int'(gate), 1);
        rst = 1'b1;
        @(negedge clk);
        check(gate == 1'b0, "R1 reset mid window", int'(gate), 0);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        check(gate == 1'b0, "R1 stays low after reset", int'(gate), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule